// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This unit collects interrupt events for an external memory interface and presents them to software through two status registers. Four external wait inputs are brought into the clock domain and watched for rising edges. A synchronous timeout strobe from the access engine provides a fifth event. Every event always sets a bit in the raw status register. The matching bit in the masked status register is set only when software has enabled that source.

Whenever at least one masked bit newly becomes set, the unit emits a single-cycle active-high pulse towards the CPU interrupt controller. Software reads the registers over a small word-addressed register bus and clears bits by writing ones. Enables are kept in one vector, which is reached through a set address and a clear address.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the raw status, masked status and enable vector read 0, and `irq_pulse` is 0.
- R2: In every register, bits 31 to 6 and bit 1 read as 0. Writes to those bits have no effect on anything that can be read back.
- R3: Wait input k (k = 0..3) maps to status bit k+2. A 0-to-1 change sets the raw bit on the third rising clock edge after the input is first sampled high. Holding the input high does not set the bit again, and a falling change sets nothing.
- R4: An event sets its raw bit whether or not it is enabled. The masked bit is set only if the source's enable bit is 1 when the event occurs. Enabling a source whose raw bit is already set does not set its masked bit.
- R5: A high `timeout_evt` at a rising clock edge is an event for status bit 0 at that edge.
- R6: Writing to address 1 (masked status) clears each masked bit and its raw bit where the data holds 1. Data bits holding 0 leave both bits unchanged.
- R7: Writing to address 0 (raw status) clears each raw bit where the data holds 1 and leaves the masked bits unchanged.
- R8: If an event and a clearing write hit the same bit at the same edge, the bit stays set.
- R9: Writing 1s to address 2 sets enable bits, and writing 1s to address 3 clears them. Zeros leave enable bits unchanged. Reading address 2 or 3 returns the enable vector.
- R10: `irq_pulse` is high for exactly the cycles in which the masked status register first shows one or more newly set bits. It stays low while bits only remain set or are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_pin | input | 4 | Asynchronous external wait inputs; bit k feeds status bit k+2 |
| timeout_evt | input | 1 | Synchronous timeout event strobe, feeds status bit 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 raw, 1 masked, 2 enable set, 3 enable clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from current state |
| irq_pulse | output | 1 | One-cycle interrupt pulse to the CPU interrupt controller |

## Verification
A timeout strobe and a register write take effect at the same edge that samples them. A wait input reaches the status registers on the third edge after it is sampled high. The interrupt pulse rises in the same cycle as the masked bit that caused it, and read data follows the addressed state with no register stage. The bench applies every input on the falling clock edge, samples outputs one time unit later, and moves a cycle-level model forward at each rising edge, so each check compares the state of the previous edge.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   typedef enum logic [1:0] {
      REG_RAW = 2'd0,
      REG_MSK = 2'd1,
      REG_ENS = 2'd2,
      REG_ENC = 2'd3
   } reg_sel_e;

   localparam int unsigned ADDR_W = 2;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned N      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < N; g++) begin : g_ch
      logic [STAGES-1:0] chain;
      logic              prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], pin_i[g]};
            prev  <= chain[STAGES-1];
         end
      end

      assign rise_o[g] = chain[STAGES-1] & ~prev;
   end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned             POS_W = 6,
   parameter logic [POS_W-1:0]        IMPL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] evt_i,
   input  logic [POS_W-1:0] en_i,
   input  logic [POS_W-1:0] clr_raw_i,
   input  logic [POS_W-1:0] clr_msk_i,
   output logic [POS_W-1:0] raw_o,
   output logic [POS_W-1:0] msk_o,
   output logic             irq_o
);

   logic [POS_W-1:0] msk_d;
   logic             irq_q;

   for (genvar g = 0; g < POS_W; g++) begin : g_bit
      if (IMPL[g]) begin : g_impl
         logic r_bit;
         logic m_bit;
         logic r_nxt;
         logic m_nxt;

         // an event in the same cycle overrides any clear
         assign r_nxt = (r_bit & ~(clr_raw_i[g] | clr_msk_i[g])) | evt_i[g];
         assign m_nxt = (m_bit & ~clr_msk_i[g]) | (evt_i[g] & en_i[g]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_bit <= 1'b0;
               m_bit <= 1'b0;
            end else begin
               r_bit <= r_nxt;
               m_bit <= m_nxt;
            end
         end

         assign raw_o[g] = r_bit;
         assign msk_o[g] = m_bit;
         assign msk_d[g] = m_nxt;
      end else begin : g_rsvd
         logic unused_b;
         assign unused_b = evt_i[g] ^ en_i[g] ^ clr_raw_i[g] ^ clr_msk_i[g];
         assign raw_o[g] = 1'b0;
         assign msk_o[g] = 1'b0;
         assign msk_d[g] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(msk_d & ~msk_o);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
   import irq_stat_pkg::*;
#(
   parameter int unsigned      DATA_W = 32,
   parameter int unsigned      POS_W  = 6,
   parameter logic [POS_W-1:0] IMPL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [POS_W-1:0]  raw_i,
   input  logic [POS_W-1:0]  msk_i,
   output logic [POS_W-1:0]  clr_raw_o,
   output logic [POS_W-1:0]  clr_msk_o,
   output logic [POS_W-1:0]  en_o
);

   reg_sel_e         sel;
   logic [POS_W-1:0] wbits;
   logic [POS_W-1:0] en_set;
   logic [POS_W-1:0] en_clr;
   logic [POS_W-1:0] en_q;
   logic [POS_W-1:0] rd_bits;
   logic             unused_wdata_hi;

   assign sel             = reg_sel_e'(bus_addr);
   assign wbits           = bus_wdata[POS_W-1:0] & IMPL;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:POS_W];

   assign clr_raw_o = (bus_wr && sel == REG_RAW) ? wbits : '0;
   assign clr_msk_o = (bus_wr && sel == REG_MSK) ? wbits : '0;
   assign en_set    = (bus_wr && sel == REG_ENS) ? wbits : '0;
   assign en_clr    = (bus_wr && sel == REG_ENC) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q | en_set) & ~en_clr;
   end

   assign en_o = en_q;

   always_comb begin
      unique case (sel)
         REG_RAW: rd_bits = raw_i;
         REG_MSK: rd_bits = msk_i;
         default: rd_bits = en_q;
      endcase
      bus_rdata               = '0;
      bus_rdata[POS_W-1:0]    = rd_bits & IMPL;
   end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_stat_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned WAIT_N      = 4,
   parameter int unsigned WAIT_LSB    = 2,
   parameter int unsigned TO_BIT      = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WAIT_N-1:0] wait_pin,
   input  logic              timeout_evt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_pulse
);

   localparam int unsigned      POS_W     = WAIT_LSB + WAIT_N;
   localparam logic [POS_W-1:0] WAIT_MASK = POS_W'(((1 << WAIT_N) - 1) << WAIT_LSB);
   localparam logic [POS_W-1:0] TO_MASK   = POS_W'(1 << TO_BIT);
   localparam logic [POS_W-1:0] IMPL      = WAIT_MASK | TO_MASK;

   if (WAIT_N < 1) begin : g_bad_wait_n
      $error("irq_status_unit: WAIT_N must be at least 1");
   end
   if (TO_BIT >= WAIT_LSB) begin : g_bad_to_bit
      $error("irq_status_unit: TO_BIT must lie below WAIT_LSB");
   end
   if (POS_W >= DATA_W) begin : g_bad_data_w
      $error("irq_status_unit: status field must be narrower than DATA_W");
   end

   logic [WAIT_N-1:0] wait_rise;
   logic [POS_W-1:0]  evt_v;
   logic [POS_W-1:0]  raw_q;
   logic [POS_W-1:0]  msk_q;
   logic [POS_W-1:0]  en_q;
   logic [POS_W-1:0]  clr_raw;
   logic [POS_W-1:0]  clr_msk;

   irq_edge_sync #(
      .N      (WAIT_N),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (wait_pin),
      .rise_o (wait_rise)
   );

   always_comb begin
      evt_v                      = '0;
      evt_v[WAIT_LSB +: WAIT_N]  = wait_rise;
      evt_v[TO_BIT]              = timeout_evt;
   end

   irq_status_bank #(
      .POS_W (POS_W),
      .IMPL  (IMPL)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_v),
      .en_i      (en_q),
      .clr_raw_i (clr_raw),
      .clr_msk_i (clr_msk),
      .raw_o     (raw_q),
      .msk_o     (msk_q),
      .irq_o     (irq_pulse)
   );

   irq_reg_if #(
      .DATA_W (DATA_W),
      .POS_W  (POS_W),
      .IMPL   (IMPL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .raw_i     (raw_q),
      .msk_i     (msk_q),
      .clr_raw_o (clr_raw),
      .clr_msk_o (clr_msk),
      .en_o      (en_q)
   );

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
   import irq_stat_pkg::*;
#(
   parameter int unsigned      DATA_W = 32,
   parameter int unsigned      POS_W  = 6,
   parameter logic [POS_W-1:0] IMPL   = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_pulse,
   input logic [POS_W-1:0]  raw_q,
   input logic [POS_W-1:0]  msk_q,
   input logic [POS_W-1:0]  en_q,
   input logic [POS_W-1:0]  evt_v
);

   logic unused_hi;
   assign unused_hi = ^bus_wdata[DATA_W-1:POS_W];

   // R2: reserved positions never read back as 1
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[DATA_W-1:POS_W] == '0) && ((bus_rdata[POS_W-1:0] & ~IMPL) == '0));

   // R4: a masked bit can only rise if its enable was on
   a_r4_masked_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q & ~$past(msk_q) & ~$past(en_q)) == '0);

   // R6: a masked-register clear without a competing event empties both bits
   a_r6_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_MSK) |=>
      ((msk_q | raw_q) & $past(bus_wdata[POS_W-1:0] & IMPL & ~evt_v)) == '0);

   // R8: an event always leaves its raw bit set
   a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & $past(evt_v)) == $past(evt_v)));

   // R10: pulse only when a masked bit newly appears
   a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ((msk_q & ~$past(msk_q)) != '0));

   // R10: every newly set masked bit comes with a pulse
   a_r10_cause_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ((msk_q & ~$past(msk_q)) != '0) |-> irq_pulse);

endmodule

bind irq_status_unit irq_status_unit_chk #(
   .DATA_W (DATA_W),
   .POS_W  (POS_W),
   .IMPL   (IMPL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_pulse (irq_pulse),
   .raw_q     (raw_q),
   .msk_q     (msk_q),
   .en_q      (en_q),
   .evt_v     (evt_v)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] IMPL = 6'b111101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  wait_pin = '0;
   logic        timeout_evt = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_pulse;

   int n_chk  = 0;
   int n_fail = 0;

   // model state
   logic [5:0] m_raw = '0, m_msk = '0, m_en = '0;
   logic       m_irq = 1'b0;
   logic [3:0] p1 = '0, p2 = '0, p3 = '0;

   irq_status_unit dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wait_pin    (wait_pin),
      .timeout_evt (timeout_evt),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_pulse   (irq_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] exp_read(input logic [1:0] a);
      logic [5:0] v;
      case (a)
         2'd0:    v = m_raw;
         2'd1:    v = m_msk;
         default: v = m_en;
      endcase
      return {26'd0, v & IMPL};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one cycle: apply at falling edge, check, then advance model at rising edge
   task automatic step(input logic [3:0] pins, input logic to, input logic wr,
                       input logic [1:0] a, input logic [31:0] wd, input string tag);
      logic [5:0] evt, clr_r, clr_m, wb, n_raw, n_msk, n_en;
      @(negedge clk);
      wait_pin = pins; timeout_evt = to; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      #1;
      check(tag, "rdata", bus_rdata, exp_read(a));
      check(tag, "irq", {31'd0, irq_pulse}, {31'd0, m_irq});
      @(posedge clk);
      evt   = {p2 & ~p3, 1'b0, to};
      wb    = wd[5:0] & IMPL;
      clr_r = (wr && a == 2'd0) ? wb : '0;
      clr_m = (wr && a == 2'd1) ? wb : '0;
      n_raw = (m_raw & ~(clr_r | clr_m)) | evt;
      n_msk = (m_msk & ~clr_m) | (evt & m_en);
      n_en  = m_en;
      if (wr && a == 2'd2) n_en = m_en | wb;
      if (wr && a == 2'd3) n_en = m_en & ~wb;
      m_irq = |(n_msk & ~m_msk);
      m_raw = n_raw & IMPL; m_msk = n_msk & IMPL; m_en = n_en & IMPL;
      p3 = p2; p2 = p1; p1 = pins;
   endtask

   task automatic rd(input logic [3:0] pins, input logic [1:0] a, input string tag);
      step(pins, 1'b0, 1'b0, a, 32'd0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [3:0] pins;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state on every address
      for (int a = 0; a < 4; a++) rd(4'b0, 2'(a), "R1");

      // R9: enable set / clear addresses
      step(4'b0, 0, 1, 2'd2, 32'h0000_003D, "R9");
      rd(4'b0, 2'd2, "R9");
      rd(4'b0, 2'd3, "R9");
      step(4'b0, 0, 1, 2'd3, 32'h0000_0008, "R9");
      rd(4'b0, 2'd2, "R9");
      rd(4'b0, 2'd3, "R9");

      // R3: wait input 0 rises (bit 2, enabled), latency, hold, fall
      for (int i = 0; i < 6; i++) rd(4'b0001, 2'(i % 2), "R3");
      for (int i = 0; i < 4; i++) rd(4'b0000, 2'(i % 2), "R3");

      // R4: wait input 1 (bit 3, disabled) sets raw only; enabling later sets nothing
      for (int i = 0; i < 6; i++) rd(4'b0010, 2'(i % 2), "R4");
      step(4'b0010, 0, 1, 2'd2, 32'h0000_0008, "R4");
      for (int i = 0; i < 3; i++) rd(4'b0010, 2'(i % 2), "R4");

      // R5: timeout strobe
      step(4'b0010, 1, 0, 2'd1, 32'd0, "R5");
      rd(4'b0010, 2'd1, "R5");
      rd(4'b0010, 2'd0, "R5");

      // R6: clear masked bit 2 (also raw), then a zero write
      step(4'b0010, 0, 1, 2'd1, 32'h0000_0004, "R6");
      rd(4'b0010, 2'd0, "R6");
      rd(4'b0010, 2'd1, "R6");
      step(4'b0010, 0, 1, 2'd1, 32'h0000_0000, "R6");
      rd(4'b0010, 2'd1, "R6");

      // R7: clear raw bit 0 only
      step(4'b0010, 0, 1, 2'd0, 32'h0000_0001, "R7");
      rd(4'b0010, 2'd0, "R7");
      rd(4'b0010, 2'd1, "R7");

      // R8: timeout and masked clear on bit 0 in the same cycle
      step(4'b0010, 1, 1, 2'd1, 32'h0000_0001, "R8");
      rd(4'b0010, 2'd1, "R8");
      rd(4'b0010, 2'd0, "R8");

      // R2: all-ones writes everywhere, reserved bits read zero
      for (int a = 0; a < 4; a++) begin
         step(4'b0, 0, 1, 2'(a), 32'hFFFF_FFFF, "R2");
         for (int b = 0; b < 4; b++) rd(4'b0, 2'(b), "R2");
      end
      step(4'b0, 0, 1, 2'd2, 32'hFFFF_FFFF, "R2");

      // R10: random traffic, pulse checked every cycle
      pins = '0;
      for (int i = 0; i < 3000; i++) begin
         logic       to, wr;
         logic [1:0] a;
         for (int b = 0; b < 4; b++) if ($urandom_range(7) == 0) pins[b] = ~pins[b];
         to = ($urandom_range(15) == 0);
         wr = ($urandom_range(3) == 0);
         a  = 2'($urandom_range(3));
         step(pins, to, wr, a, $urandom, "R10");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule